// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block is the retirement end of an out-of-order core's reorder buffer. Instructions are entered in program order at the tail, marked completed by slot number as they finish, and retired from the head in order, up to a fixed number per cycle. An instruction flagged as non-speculative cannot execute early. When it becomes the oldest entry, the block emits a single release pulse carrying its sequence number, so that the issue logic upstream can start it. Once it has completed, it retires like any other entry.

A squash request names the sequence number of the youngest instruction that must survive. The block then removes entries from the young end of the buffer, a bounded number per cycle, until that instruction is the youngest one left. Retirement, releases and new allocations are held off for as long as the squash lasts. The block also tells earlier stages how many buffer slots are free and flags the cycles in which that number has changed. The storage is a power-of-two ring. Head and tail pointers each carry one extra wrap bit, which is how a full buffer is told apart from an empty one.

Top module: `rob_commit_ctrl`

## Requirements
- R1: Each cycle the block retires up to COMMIT_W completed entries, oldest first. Slot k of `retire_vld` and `retire_seq` (bits k*SEQ_W upward) holds the k-th oldest entry, and the valid slots are always the lowest-numbered ones. `done_valid` marks the entry in slot `done_idx` as completed.
- R2: Retirement in a cycle stops at the first entry that is not completed. No younger entry retires in that cycle, even if it is completed.
- R3: When the oldest entry is non-speculative, not completed and not yet released, `ns_release` is high for exactly one cycle and `ns_seq` shows that entry's sequence number. An entry is released only while it is the oldest, and only once.
- R4: A non-speculative entry retires only after it has been marked completed, and every entry behind it waits for it.
- R5: A squash request accepted while the block is idle raises `squash_busy` on the next cycle. In each busy cycle the block removes up to SQUASH_RATE of the youngest entries whose sequence number differs from the target. `squash_busy` falls after the first busy cycle that removes fewer than SQUASH_RATE entries, so removing n entries takes floor(n/SQUASH_RATE)+1 busy cycles. If the target is not in the buffer, every entry is removed.
- R6: In a cycle where `squash_busy` or `squash_valid` is high, nothing retires and no release is issued. While `squash_busy` is high, `alloc_ready` is low and any further squash request is ignored.
- R7: `free_cnt` is a registered value equal to DEPTH minus the occupancy left by the previous clock edge. `free_upd` is high exactly in the cycles where `free_cnt` differs from its value in the cycle before.
- R8: `alloc_ready` is low when all DEPTH entries are occupied. An accepted allocation writes the slot shown on `alloc_idx`, which is the tail position and advances by one per accepted allocation.
- R9: After reset the buffer is empty: `free_cnt` equals DEPTH, `squash_busy`, `ns_release` and `retire_vld` are all zero, `alloc_ready` is high and `alloc_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to append an instruction at the tail |
| alloc_nonspec | input | 1 | The appended instruction is non-speculative |
| alloc_seq | input | SEQ_W | Sequence number of the appended instruction |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| alloc_idx | output | log2(DEPTH) | Slot that the next allocation fills |
| done_valid | input | 1 | Mark one entry as completed |
| done_idx | input | log2(DEPTH) | Slot of the entry that completed |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Sequence number of the youngest instruction to keep |
| retire_vld | output | COMMIT_W | Per-slot retire strobes, oldest in slot 0 |
| retire_seq | output | COMMIT_W*SEQ_W | Sequence numbers of the retiring entries |
| ns_release | output | 1 | Non-speculative head instruction may now execute |
| ns_seq | output | SEQ_W | Sequence number that goes with `ns_release` |
| squash_busy | output | 1 | A squash is still removing entries |
| free_cnt | output | log2(DEPTH)+1 | Number of free buffer entries |
| free_upd | output | 1 | `free_cnt` changed in this cycle |

## Verification
The bench fills the buffer and then completes the second entry before the first. A design that skipped over an incomplete head would retire that younger entry early. It also parks a non-speculative entry at the head and checks for exactly one release pulse and no retirement. A design that released in every cycle, or let the entry retire while still incomplete, would show up there. A squash that spans several cycles has its busy cycles counted: an off-by-one in the drain rate or in the stop condition changes that count, and removing the target itself changes the final free count. A second squash is issued mid-drain, and a design that accepted it would empty the whole buffer. A long random run, checked against a reference model every cycle, covers pointer wrap, full-buffer stalls and the change flag on the free count.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;

    // Controller mode: normal retirement or draining a squash.
    typedef enum logic {
        RCC_RUN   = 1'b0,
        RCC_DRAIN = 1'b1
    } rcc_mode_e;

    // Distance from head to tail on a ring whose pointers carry a wrap bit.
    function automatic int unsigned rcc_span(input int unsigned tail,
                                             input int unsigned head,
                                             input int unsigned cnt_w);
        int unsigned mask;
        mask = (32'd1 << cnt_w) - 32'd1;
        return (tail - head) & mask;
    endfunction

endpackage

// File: rtl/rcc_store.sv
`timescale 1ns/1ps
module rcc_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned SEQ_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [$clog2(DEPTH)-1:0]          wr_idx,
    input  logic                              wr_nonspec,
    input  logic [SEQ_W-1:0]                  wr_seq,
    input  logic                              mark_en,
    input  logic [$clog2(DEPTH)-1:0]          mark_idx,
    input  logic                              rel_en,
    input  logic [$clog2(DEPTH)-1:0]          rel_idx,
    output logic [DEPTH-1:0][SEQ_W-1:0]       ent_seq,
    output logic [DEPTH-1:0]                  ent_nonspec,
    output logic [DEPTH-1:0]                  ent_done,
    output logic [DEPTH-1:0]                  ent_rel
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [SEQ_W-1:0] seq_r;
        logic             ns_r;
        logic             done_r;
        logic             rel_r;
        logic             hit_wr;
        logic             hit_mark;
        logic             hit_rel;

        assign hit_wr   = wr_en   && (wr_idx   == PTR_W'(i));
        assign hit_mark = mark_en && (mark_idx == PTR_W'(i));
        assign hit_rel  = rel_en  && (rel_idx  == PTR_W'(i));

        // Payload needs no reset: it is only read while the slot is occupied.
        always_ff @(posedge clk) begin
            if (hit_wr) begin
                seq_r <= wr_seq;
                ns_r  <= wr_nonspec;
            end
        end

        // Status flags: a fresh allocation clears them, events then set them.
        always_ff @(posedge clk) begin
            if (rst) begin
                done_r <= 1'b0;
                rel_r  <= 1'b0;
            end else if (hit_wr) begin
                done_r <= 1'b0;
                rel_r  <= 1'b0;
            end else begin
                if (hit_mark) done_r <= 1'b1;
                if (hit_rel)  rel_r  <= 1'b1;
            end
        end

        assign ent_seq[i]     = seq_r;
        assign ent_nonspec[i] = ns_r;
        assign ent_done[i]    = done_r;
        assign ent_rel[i]     = rel_r;
    end

endmodule

// File: rtl/rcc_retire_scan.sv
`timescale 1ns/1ps
module rcc_retire_scan #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 2,
    parameter int unsigned SEQ_W = 8
) (
    input  logic [$clog2(DEPTH)-1:0]    head_idx,
    input  logic [$clog2(DEPTH):0]      occ,
    input  logic                        enable,
    input  logic [DEPTH-1:0][SEQ_W-1:0] ent_seq,
    input  logic [DEPTH-1:0]            ent_nonspec,
    input  logic [DEPTH-1:0]            ent_done,
    input  logic [DEPTH-1:0]            ent_rel,
    output logic [CW-1:0]               retire_vld,
    output logic [CW-1:0][SEQ_W-1:0]    retire_seq,
    output logic [$clog2(DEPTH):0]      retire_cnt,
    output logic                        ns_release,
    output logic [SEQ_W-1:0]            ns_seq
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    // Walk from the head; the run ends at the first incomplete entry.
    always_comb begin
        logic             go;
        logic [PTR_W-1:0] idx;
        go         = enable;
        retire_cnt = '0;
        for (int k = 0; k < CW; k++) begin
            idx           = head_idx + PTR_W'(k);
            go            = go && (CNT_W'(k) < occ) && ent_done[idx];
            retire_vld[k] = go;
            retire_seq[k] = ent_seq[idx];
            retire_cnt    = retire_cnt + CNT_W'(go);
        end
    end

    // A non-speculative instruction is let go only from the head, once.
    assign ns_release = enable && (occ != '0) && ent_nonspec[head_idx]
                        && !ent_done[head_idx] && !ent_rel[head_idx];
    assign ns_seq     = ent_seq[head_idx];

endmodule

// File: rtl/rcc_squash_walk.sv
`timescale 1ns/1ps
module rcc_squash_walk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned RATE  = 2,
    parameter int unsigned SEQ_W = 8
) (
    input  logic                        active,
    input  logic [$clog2(DEPTH)-1:0]    tail_idx,
    input  logic [$clog2(DEPTH):0]      occ,
    input  logic [SEQ_W-1:0]            target,
    input  logic [DEPTH-1:0][SEQ_W-1:0] ent_seq,
    output logic [$clog2(DEPTH):0]      rm_cnt,
    output logic                        finish
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    // Peel entries off the young end until the target is the youngest left.
    always_comb begin
        logic             go;
        logic [PTR_W-1:0] idx;
        go     = active;
        rm_cnt = '0;
        for (int k = 0; k < RATE; k++) begin
            idx    = tail_idx - PTR_W'(k + 1);
            go     = go && (CNT_W'(k) < occ) && (ent_seq[idx] != target);
            rm_cnt = rm_cnt + CNT_W'(go);
        end
        finish = active && !go;
    end

endmodule

// File: rtl/rob_commit_ctrl.sv
`timescale 1ns/1ps
module rob_commit_ctrl
    import rcc_pkg::*;
#(
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned COMMIT_W    = 2,
    parameter int unsigned SQUASH_RATE = 2,
    parameter int unsigned SEQ_W       = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          alloc_valid,
    input  logic                          alloc_nonspec,
    input  logic [SEQ_W-1:0]              alloc_seq,
    output logic                          alloc_ready,
    output logic [$clog2(DEPTH)-1:0]      alloc_idx,
    input  logic                          done_valid,
    input  logic [$clog2(DEPTH)-1:0]      done_idx,
    input  logic                          squash_valid,
    input  logic [SEQ_W-1:0]              squash_seq,
    output logic [COMMIT_W-1:0]           retire_vld,
    output logic [COMMIT_W*SEQ_W-1:0]     retire_seq,
    output logic                          ns_release,
    output logic [SEQ_W-1:0]              ns_seq,
    output logic                          squash_busy,
    output logic [$clog2(DEPTH):0]        free_cnt,
    output logic                          free_upd
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    // Pointers carry a wrap bit above the slot index.
    logic [CNT_W-1:0] head_q, tail_q, head_d, tail_d;
    logic [CNT_W-1:0] occ, occ_d, free_d, free_q;
    logic             upd_q;
    rcc_mode_e        mode_q, mode_d;
    logic [SEQ_W-1:0] target_q;
    logic             busy, full, alloc_fire, scan_en;

    logic [DEPTH-1:0][SEQ_W-1:0] ent_seq;
    logic [DEPTH-1:0]            ent_nonspec, ent_done, ent_rel;
    logic [COMMIT_W-1:0][SEQ_W-1:0] scan_seq;
    logic [CNT_W-1:0]            retire_cnt, rm_cnt;
    logic                        walk_finish;

    assign busy        = (mode_q == RCC_DRAIN);
    assign occ         = CNT_W'(rcc_span(32'(tail_q), 32'(head_q), CNT_W));
    assign full        = (occ == CNT_W'(DEPTH));
    assign alloc_ready = !full && !busy;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_idx   = tail_q[PTR_W-1:0];
    assign scan_en     = !busy && !squash_valid;

    rcc_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (alloc_fire),
        .wr_idx      (tail_q[PTR_W-1:0]),
        .wr_nonspec  (alloc_nonspec),
        .wr_seq      (alloc_seq),
        .mark_en     (done_valid),
        .mark_idx    (done_idx),
        .rel_en      (ns_release),
        .rel_idx     (head_q[PTR_W-1:0]),
        .ent_seq     (ent_seq),
        .ent_nonspec (ent_nonspec),
        .ent_done    (ent_done),
        .ent_rel     (ent_rel)
    );

    rcc_retire_scan #(.DEPTH(DEPTH), .CW(COMMIT_W), .SEQ_W(SEQ_W)) u_scan (
        .head_idx    (head_q[PTR_W-1:0]),
        .occ         (occ),
        .enable      (scan_en),
        .ent_seq     (ent_seq),
        .ent_nonspec (ent_nonspec),
        .ent_done    (ent_done),
        .ent_rel     (ent_rel),
        .retire_vld  (retire_vld),
        .retire_seq  (scan_seq),
        .retire_cnt  (retire_cnt),
        .ns_release  (ns_release),
        .ns_seq      (ns_seq)
    );

    rcc_squash_walk #(.DEPTH(DEPTH), .RATE(SQUASH_RATE), .SEQ_W(SEQ_W)) u_walk (
        .active   (busy),
        .tail_idx (tail_q[PTR_W-1:0]),
        .occ      (occ),
        .target   (target_q),
        .ent_seq  (ent_seq),
        .rm_cnt   (rm_cnt),
        .finish   (walk_finish)
    );

    for (genvar k = 0; k < COMMIT_W; k++) begin : g_rseq
        assign retire_seq[k*SEQ_W +: SEQ_W] = scan_seq[k];
    end

    // Next-state pointers and the free count they imply.
    assign head_d = head_q + retire_cnt;
    assign tail_d = tail_q + CNT_W'(alloc_fire) - rm_cnt;
    assign occ_d  = tail_d - head_d;
    assign free_d = CNT_W'(DEPTH) - occ_d;

    always_comb begin
        unique case (mode_q)
            RCC_RUN:   mode_d = squash_valid ? RCC_DRAIN : RCC_RUN;
            RCC_DRAIN: mode_d = walk_finish  ? RCC_RUN   : RCC_DRAIN;
            default:   mode_d = RCC_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            tail_q   <= '0;
            mode_q   <= RCC_RUN;
            target_q <= '0;
            free_q   <= CNT_W'(DEPTH);
            upd_q    <= 1'b0;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
            mode_q <= mode_d;
            if (!busy && squash_valid) target_q <= squash_seq;
            free_q <= free_d;
            upd_q  <= (free_d != free_q);
        end
    end

    assign squash_busy = busy;
    assign free_cnt    = free_q;
    assign free_upd    = upd_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));  // R8
    AST_DRAIN_HALTS_RETIRE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (retire_vld == '0) && !ns_release);  // R6
    AST_DRAIN_NEVER_GROWS: assert property (@(posedge clk) disable iff (rst)
        busy |=> (occ <= $past(occ)));  // R5
    AST_FREE_TRACKS_OCC: assert property (@(posedge clk) disable iff (rst)
        free_cnt == CNT_W'(DEPTH) - occ);  // R7
    AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        free_upd |-> (free_cnt != $past(free_cnt)));  // R7
    AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (rst)
        ns_release |=> !ns_release);  // R3
    AST_RETIRE_WITHIN_OCC: assert property (@(posedge clk) disable iff (rst)
        retire_cnt <= occ);  // R1

endmodule

// File: tb/rob_commit_ctrl_tb.sv
`timescale 1ns/1ps
module rob_commit_ctrl_tb;
    localparam int DEPTH = 8;
    localparam int CW    = 2;
    localparam int RATE  = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       alloc_valid, alloc_nonspec, alloc_ready;
    logic [7:0] alloc_seq;
    logic [2:0] alloc_idx;
    logic       done_valid;
    logic [2:0] done_idx;
    logic       squash_valid;
    logic [7:0] squash_seq;
    logic [1:0] retire_vld;
    logic [15:0] retire_seq;
    logic       ns_release;
    logic [7:0] ns_seq;
    logic       squash_busy;
    logic [3:0] free_cnt;
    logic       free_upd;

    always #2 clk = ~clk;

    rob_commit_ctrl #(.DEPTH(DEPTH), .COMMIT_W(CW), .SQUASH_RATE(RATE), .SEQ_W(8)) u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_nonspec(alloc_nonspec), .alloc_seq(alloc_seq),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .done_valid(done_valid), .done_idx(done_idx),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .retire_vld(retire_vld), .retire_seq(retire_seq),
        .ns_release(ns_release), .ns_seq(ns_seq),
        .squash_busy(squash_busy), .free_cnt(free_cnt), .free_upd(free_upd)
    );

    int checks = 0;
    int errors = 0;

    // Reference model of the buffer contents.
    int m_head, m_tail, m_tgt, m_free;
    bit m_busy, m_upd;
    bit m_ns[DEPTH], m_done[DEPTH], m_rel[DEPTH];
    int m_seq[DEPTH];
    int seq_ctr;

    // Last observed outputs.
    bit [1:0] obs_rv;
    bit       obs_rel, obs_busy, obs_rdy, obs_upd;
    int       obs_free, obs_nsseq;
    int       obs_rseq[CW];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit av, input bit ans, input bit dv, input int didx,
                        input bit sv, input int sseq);
        int occ, h, nrm, rcnt, nf;
        bit en, erel, rdy, fin, fire, run;
        bit [1:0] erv;
        @(negedge clk);
        occ  = (m_tail - m_head) & 15;
        rdy  = (occ < DEPTH) && !m_busy;
        fire = av && rdy;
        alloc_valid   = av;
        alloc_nonspec = ans;
        alloc_seq     = 8'(seq_ctr);
        done_valid    = dv;
        done_idx      = 3'(didx);
        squash_valid  = sv;
        squash_seq    = 8'(sseq);
        #1;
        // Expected combinational outputs for this cycle.
        en = !m_busy && !sv;
        h  = m_head & 7;
        erv = 2'b00; rcnt = 0; run = en;
        for (int k = 0; k < CW; k++) begin
            if (run && k < occ && m_done[(m_head + k) & 7]) begin
                erv[k] = 1'b1; rcnt++;
            end else run = 1'b0;
        end
        erel = en && occ > 0 && m_ns[h] && !m_done[h] && !m_rel[h];
        nrm = 0;
        if (m_busy) begin
            for (int k = 0; k < RATE; k++) begin
                if (nrm == k && k < occ && m_seq[(m_tail - 1 - k) & 7] != m_tgt) nrm++;
            end
        end
        fin = m_busy && (nrm < RATE);
        obs_rv = retire_vld; obs_rel = ns_release; obs_busy = squash_busy;
        obs_rdy = alloc_ready; obs_free = free_cnt; obs_upd = free_upd;
        obs_nsseq = ns_seq;
        for (int k = 0; k < CW; k++) obs_rseq[k] = retire_seq[k*8 +: 8];
        chk("R1", "retire_vld", retire_vld, erv);
        for (int k = 0; k < CW; k++)
            if (erv[k]) chk("R1", "retire_seq", obs_rseq[k], m_seq[(m_head + k) & 7]);
        chk("R3", "ns_release", ns_release, erel);
        if (erel) chk("R3", "ns_seq", ns_seq, m_seq[h]);
        chk("R5", "squash_busy", squash_busy, m_busy);
        chk("R7", "free_cnt", free_cnt, m_free);
        chk("R7", "free_upd", free_upd, m_upd);
        chk("R8", "alloc_ready", alloc_ready, rdy);
        chk("R8", "alloc_idx", alloc_idx, m_tail & 7);
        // Advance the model across the coming edge.
        if (fire) begin
            m_seq[m_tail & 7] = seq_ctr; m_ns[m_tail & 7] = ans;
            m_done[m_tail & 7] = 0; m_rel[m_tail & 7] = 0;
            seq_ctr = (seq_ctr + 1) & 255;
        end
        if (dv) m_done[didx] = 1;
        if (erel) m_rel[h] = 1;
        m_head = (m_head + rcnt) & 15;
        m_tail = (m_tail + (fire ? 1 : 0) - nrm) & 15;
        if (m_busy) m_busy = !fin;
        else if (sv) begin m_busy = 1; m_tgt = sseq; end
        nf = DEPTH - ((m_tail - m_head) & 15);
        m_upd = (nf != m_free);
        m_free = nf;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [31:0] r;
        int occ, o, didx, sseq, cnt;
        bit av, ans, dv, sv;
        rst = 1'b1;
        alloc_valid = 0; alloc_nonspec = 0; alloc_seq = 0;
        done_valid = 0; done_idx = 0; squash_valid = 0; squash_seq = 0;
        m_head = 0; m_tail = 0; m_busy = 0; m_tgt = 0; m_free = DEPTH; m_upd = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_ns[i] = 0; m_done[i] = 0; m_rel[i] = 0; m_seq[i] = 0;
        end
        seq_ctr = 10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset state
        chk("R9", "free_cnt", free_cnt, DEPTH);
        chk("R9", "squash_busy", squash_busy, 0);
        chk("R9", "retire_vld", retire_vld, 0);
        chk("R9", "ns_release", ns_release, 0);
        chk("R9", "alloc_ready", alloc_ready, 1);
        chk("R9", "alloc_idx", alloc_idx, 0);

        // Fill the ring; slot 2 holds a non-speculative instruction.
        for (int i = 0; i < DEPTH; i++) step(1, i == 2, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R8", "full blocks alloc", obs_rdy, 0);
        chk("R7", "free when full", obs_free, 0);

        // R2: younger entry completed first must wait.
        step(0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R2", "no skip past head", obs_rv, 0);
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R1", "two retire", obs_rv, 3);
        chk("R1", "slot0 seq", obs_rseq[0], 10);
        chk("R1", "slot1 seq", obs_rseq[1], 11);

        // R3/R4: non-speculative head.
        step(0, 0, 0, 0, 0, 0);
        chk("R3", "release pulse", obs_rel, 1);
        chk("R3", "release seq", obs_nsseq, 12);
        chk("R4", "held at head", obs_rv, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R3", "single release", obs_rel, 0);
        step(0, 0, 1, 2, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R4", "retires once done", obs_rv, 1);
        chk("R4", "retire seq", obs_rseq[0], 12);

        // R5/R6: squash back to seq 13, with a second request mid-drain.
        step(0, 0, 0, 0, 1, 13);
        step(1, 0, 0, 0, 1, 99);
        chk("R6", "alloc blocked", obs_rdy, 0);
        cnt = obs_busy ? 1 : 0;
        for (int g = 0; g < 20; g++) begin
            step(0, 0, 0, 0, 0, 0);
            if (!obs_busy) break;
            cnt++;
        end
        chk("R5", "busy cycles", cnt, 3);
        chk("R6", "second squash ignored", obs_free, 7);

        // Long mixed run against the model.
        r = 32'h1234_5678;
        for (int c = 0; c < 4000; c++) begin
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            occ = (m_tail - m_head) & 15;
            av  = (r[1:0] != 0);
            ans = (r[3:2] == 0);
            dv = 0; didx = 0; sv = 0; sseq = 0;
            if (occ > 0) begin
                o = int'(r[10:8]) % occ;
                didx = (m_head + o) & 7;
                if (!m_done[didx] && (!m_ns[didx] || m_rel[didx]) && r[4]) dv = 1;
                sv = (r[15:11] == 0);
                sseq = m_seq[(m_head + int'(r[20:18]) % occ) & 7];
            end
            step(av, ans, dv, didx, sv, sseq);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule